// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gathers ten event sources of a serial peripheral into one interrupt line. Software never writes the mask directly. It writes ones to an enable port to arm sources and ones to a disable port to disarm them. The resulting mask can only be read. An event reaches the latched status register only while its mask bit is set. Software clears status bits by writing ones to a status-clear port. The interrupt line is a registered OR of every status bit that is also masked in.

A second, raw view shows the event inputs as they arrived, sampled once per clock, whatever the mask holds. Both views and the mask share one read selector. The two write-only ports appear on that selector as well and read back as zero. Index 0 through 9 of every vector follow this order: receive trigger, receive empty, receive full, transmit empty, transmit full, overrun, framing, parity, timeout, modem status change.

Top module: `irq_mask_ctrl`

## Requirements
- R1: After reset the mask, the latched status, the raw view and `irq_o` are all zero.
- R2: On a clock with `en_we` high, every bit that is 1 in `en_bits` becomes 1 in the mask. Bits that are 0 in `en_bits` keep their value.
- R3: On a clock with `dis_we` high, every bit that is 1 in `dis_bits` becomes 0 in the mask. Bits that are 0 in `dis_bits` keep their value.
- R4: When the enable port and the disable port name the same bit on the same clock, that mask bit ends up 0.
- R5: A status bit is set on a clock only if its `evt_i` bit is 1 and its mask bit was 1 before that clock. An event on a bit that is masked off leaves the status bit unchanged.
- R6: On a clock with `clr_we` high, every status bit whose `clr_bits` bit is 1 is cleared. Status bits whose `clr_bits` bit is 0 keep their value.
- R7: When a qualifying event and a status clear hit the same bit on the same clock, the status bit ends up 1.
- R8: `irq_o` equals the OR of (status AND mask) as it stood one clock earlier.
- R9: The raw view holds the `evt_i` vector sampled at the last clock, whatever the mask holds.
- R10: `rd_data` is driven by `rd_sel` as follows: 0 gives the mask, 1 gives the status, 2 gives the raw view, 3 gives the enable port, 4 gives the disable port, and 5 to 7 give a reserved value. Codes 3 through 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Write strobe for the enable (set) port |
| en_bits | input | 10 | Bits to arm in the mask |
| dis_we | input | 1 | Write strobe for the disable (clear) port |
| dis_bits | input | 10 | Bits to disarm in the mask |
| clr_we | input | 1 | Write strobe for the status-clear port |
| clr_bits | input | 10 | Status bits to clear (write one to clear) |
| evt_i | input | 10 | Event inputs, one per source |
| rd_sel | input | 3 | Read selector, codes as in R10 |
| rd_data | output | 10 | Selected read value |
| irq_o | output | 1 | Interrupt line |

## Verification
Two pairs of actions can land on the same clock and compete for one bit. The first pair is an enable-port write and a disable-port write. The second pair is a qualifying event and a status-clear write. Directed phases provoke each collision by writing both ports for an identical bit in the same cycle. Long random phases then drive all strobes at high density so that partial overlaps happen often. On every clock, a behavioural model applies the chosen priority: disable wins over enable, and event wins over clear. All five read views and the interrupt line are compared against that model.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_STAT = 3'd1,
    SEL_RAW  = 3'd2,
    SEL_ENP  = 3'd3,
    SEL_DISP = 3'd4
  } rd_sel_e;

  localparam int SRC_RX_TRIG  = 0;
  localparam int SRC_RX_EMPTY = 1;
  localparam int SRC_RX_FULL  = 2;
  localparam int SRC_TX_EMPTY = 3;
  localparam int SRC_TX_FULL  = 4;
  localparam int SRC_OVERRUN  = 5;
  localparam int SRC_FRAMING  = 6;
  localparam int SRC_PARITY   = 7;
  localparam int SRC_TIMEOUT  = 8;
  localparam int SRC_MODEM    = 9;
  localparam int SRC_COUNT    = 10;
endpackage

// File: rtl/irqm_mask.sv
module irqm_mask #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic [N-1:0] set_bits,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] set_vec,
  output logic [N-1:0] clr_vec,
  output logic [N-1:0] msk_q
);
  // Disable beats enable when both name the same bit.
  function automatic logic [N-1:0] next_mask(input logic [N-1:0] cur,
                                             input logic [N-1:0] s,
                                             input logic [N-1:0] c);
    return (cur | s) & ~c;
  endfunction

  assign set_vec = set_we ? set_bits : '0;
  assign clr_vec = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) msk_q <= '0;
    else        msk_q <= next_mask(msk_q, set_vec, clr_vec);
  end
endmodule

// File: rtl/irqm_status.sv
module irqm_status #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] msk,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] arm_vec,
  output logic [N-1:0] wipe_vec,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] raw_q
);
  // Event beats clear when both hit the same bit.
  function automatic logic [N-1:0] next_status(input logic [N-1:0] cur,
                                               input logic [N-1:0] arm,
                                               input logic [N-1:0] wipe);
    return (cur & ~wipe) | arm;
  endfunction

  assign arm_vec  = evt & msk;
  assign wipe_vec = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q <= '0;
      raw_q <= '0;
    end else begin
      sts_q <= next_status(sts_q, arm_vec, wipe_vec);
      raw_q <= evt;
    end
  end
endmodule

// File: rtl/irqm_rdmux.sv
module irqm_rdmux
  import irqm_pkg::*;
#(
  parameter int N = 10
) (
  input  logic [2:0]   sel,
  input  logic [N-1:0] msk,
  input  logic [N-1:0] sts,
  input  logic [N-1:0] raw,
  output logic [N-1:0] data
);
  always_comb begin
    unique case (rd_sel_e'(sel))
      SEL_MASK: data = msk;
      SEL_STAT: data = sts;
      SEL_RAW:  data = raw;
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
  parameter int NSRC = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_bits,
  input  logic            dis_we,
  input  logic [NSRC-1:0] dis_bits,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_bits,
  input  logic [NSRC-1:0] evt_i,
  input  logic [2:0]      rd_sel,
  output logic [NSRC-1:0] rd_data,
  output logic            irq_o
);
  logic [NSRC-1:0] msk_q, sts_q, raw_q;
  logic [NSRC-1:0] set_vec, clr_vec, arm_vec, wipe_vec;
  logic            pend_any;
  logic            irq_q;

  irqm_mask #(.N(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .set_we(en_we), .set_bits(en_bits),
    .clr_we(dis_we), .clr_bits(dis_bits),
    .set_vec(set_vec), .clr_vec(clr_vec), .msk_q(msk_q)
  );

  irqm_status #(.N(NSRC)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .evt(evt_i), .msk(msk_q),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .arm_vec(arm_vec), .wipe_vec(wipe_vec),
    .sts_q(sts_q), .raw_q(raw_q)
  );

  irqm_rdmux #(.N(NSRC)) u_rd (
    .sel(rd_sel), .msk(msk_q), .sts(sts_q), .raw(raw_q), .data(rd_data)
  );

  assign pend_any = |(sts_q & msk_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend_any;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int NSRC = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_we,
  input logic            dis_we,
  input logic [NSRC-1:0] set_vec,
  input logic [NSRC-1:0] clr_vec,
  input logic [NSRC-1:0] evt_i,
  input logic [NSRC-1:0] msk_q,
  input logic [NSRC-1:0] sts_q,
  input logic [2:0]      rd_sel,
  input logic [NSRC-1:0] rd_data,
  input logic            irq_o
);
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> ((msk_q & $past(set_vec & ~clr_vec)) == $past(set_vec & ~clr_vec)));
  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((msk_q & $past(clr_vec)) == '0));
  // R4
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && dis_we) |=> ((msk_q & $past(set_vec & clr_vec)) == '0));
  // R5
  masked_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(msk_q)) == '0));
  // R7
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & msk_q) != '0) |=> ((sts_q & $past(evt_i & msk_q)) == $past(evt_i & msk_q)));
  // R8
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(sts_q & msk_q))));
  // R10
  port_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= 3'd3) |-> (rd_data == '0));
endmodule

bind irq_mask_ctrl irq_mask_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_we(en_we), .dis_we(dis_we),
  .set_vec(set_vec), .clr_vec(clr_vec), .evt_i(evt_i),
  .msk_q(msk_q), .sts_q(sts_q), .rd_sel(rd_sel), .rd_data(rd_data),
  .irq_o(irq_o)
);

// File: tb/sim_irq_mask_ctrl.sv
`timescale 1ns/1ps
module sim_irq_mask_ctrl;
  localparam int N = 10;
  localparam logic [N-1:0] ALL = 10'h3FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_we = 1'b0, dis_we = 1'b0, clr_we = 1'b0;
  logic [N-1:0] en_bits = '0, dis_bits = '0, clr_bits = '0, evt_i = '0;
  logic [2:0] rd_sel = 3'd0;
  logic [N-1:0] rd_data;
  logic irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  logic [N-1:0] m_mask = '0, m_sts = '0, m_raw = '0;
  logic m_irq = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_ctrl #(.NSRC(N)) u0 (
    .clk(clk), .rst_n(rst_n),
    .en_we(en_we), .en_bits(en_bits),
    .dis_we(dis_we), .dis_bits(dis_bits),
    .clr_we(clr_we), .clr_bits(clr_bits),
    .evt_i(evt_i), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  task automatic cmp(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // Compare every view; called away from the clock edge.
  task automatic check_all(input string tag);
    rd_sel = 3'd0; #0.1; cmp({tag, " R2 R3 R4 mask"}, rd_data, m_mask);
    rd_sel = 3'd1; #0.1; cmp({tag, " R5 R6 R7 status"}, rd_data, m_sts);
    rd_sel = 3'd2; #0.1; cmp({tag, " R9 raw"}, rd_data, m_raw);
    for (int s = 3; s < 8; s++) begin
      rd_sel = 3'(s); #0.1; cmp({tag, " R10 port-read"}, rd_data, '0);
    end
    cmp({tag, " R8 irq"}, {{(N-1){1'b0}}, irq_o}, {{(N-1){1'b0}}, m_irq});
  endtask

  // One clock: drive at negedge, advance model at posedge, compare at next negedge.
  task automatic step(input logic ew, input logic [N-1:0] eb,
                      input logic dw, input logic [N-1:0] db,
                      input logic cw, input logic [N-1:0] cb,
                      input logic [N-1:0] ev);
    logic [N-1:0] nm, ns;
    logic ni;
    en_we = ew; en_bits = eb; dis_we = dw; dis_bits = db;
    clr_we = cw; clr_bits = cb; evt_i = ev;
    @(posedge clk);
    nm = m_mask;
    for (int i = 0; i < N; i++) begin
      if (ew && eb[i]) nm[i] = 1'b1;
      if (dw && db[i]) nm[i] = 1'b0;
    end
    ns = m_sts;
    for (int i = 0; i < N; i++) begin
      if (cw && cb[i]) ns[i] = 1'b0;
      if (ev[i] && m_mask[i]) ns[i] = 1'b1;
    end
    ni = 1'b0;
    for (int i = 0; i < N; i++) if (m_sts[i] && m_mask[i]) ni = 1'b1;
    m_mask = nm; m_sts = ns; m_raw = ev; m_irq = ni;
    cyc++;
    @(negedge clk);
    check_all("");
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, '0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after-reset");

    // R5: event on masked-off bits is dropped, raw still shows it (R9)
    step(0, '0, 0, '0, 0, '0, 10'h2A5);
    idle();
    // R2: enable some bits, zeros leave others alone
    step(1, 10'h00F, 0, '0, 0, '0, '0);
    step(1, 10'h300, 0, '0, 0, '0, '0);
    // R5 + R8: qualified event latches, irq next cycle
    step(0, '0, 0, '0, 0, '0, 10'h001);
    idle(); idle();
    // R3: disable drops irq while status stays
    step(0, '0, 1, 10'h001, 0, '0, '0);
    idle();
    // R4: enable and disable same bit
    step(1, 10'h0F0, 1, 10'h030, 0, '0, '0);
    idle();
    // R6: write one to clear, zero bits untouched
    step(1, 10'h001, 0, '0, 0, '0, 10'h302);
    step(0, '0, 0, '0, 1, 10'h001, '0);
    idle();
    // R7: event and clear on the same bit
    step(0, '0, 0, '0, 1, 10'h202, 10'h200);
    idle();
    step(0, '0, 0, '0, 1, ALL, '0);
    idle(); idle();

    // dense random phase
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] a, b, c, e;
      a = N'($urandom); b = N'($urandom); c = N'($urandom); e = N'($urandom);
      step(1'($urandom), a, 1'($urandom), ($urandom % 3 == 0) ? a : b,
           1'($urandom), ($urandom % 3 == 0) ? e : c, e);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule